// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block orders two 32-bit binary floating-point operands and writes the outcome as a 2-bit condition code into a field of a 32-bit status register that it holds. A request carries both operands and a flag that picks the variant. The quiet variant only reports the ordering. The signaling variant also raises an invalid-operation flag whenever either operand is not a number. Any signaling-NaN operand raises the invalid flag in both variants.

Zeros, infinities, subnormal values and NaNs are all handled. The status register can be loaded whole through a separate port, so that software-visible bits outside the condition-code field pass through the block unchanged. The result, the status register and the invalid flag are registered. They update on the clock edge that accepts a request, and a one-cycle done pulse marks that update.

Top module: `fpcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, mantissa nonzero), the condition code is unordered (3).
- R2: In the signaling variant (`req_signaling`=1), any NaN operand sets `invalid` to 1 with the result.
- R3: A signaling NaN (mantissa MSB 0) sets `invalid` in the quiet variant too. A quiet NaN (mantissa MSB 1) in the quiet variant leaves `invalid` at 0, and a compare without a NaN never sets it.
- R4: Two zeros compare equal (code 0) whatever their signs.
- R5: When the signs differ and the operands are not both zero, a negative first operand gives less-than (code 1) and a positive one gives greater-than (code 2).
- R6: With equal signs, magnitudes rank infinity above finite nonzero values, which rank above zero. The magnitude ordering is reversed when both operands are negative.
- R7: Two infinities of the same sign compare equal.
- R8: Two finite nonzero operands of the same sign, subnormals included, are ordered by their unsigned exponent-and-mantissa magnitude. Equal magnitudes give equal.
- R9: The code sits at status bits [CC_LSB+1:CC_LSB] (default 11:10) with 0 equal, 1 less, 2 greater and 3 unordered. A compare leaves every other status bit unchanged.
- R10: `stat_load` writes the whole status register with `stat_din`. When it coincides with an accepted request, the code field comes from the compare and every other bit comes from `stat_din`.
- R11: After reset the status, `done` and `invalid` are 0 and `req_ready` is 1. `done` pulses high for exactly one cycle, in the cycle after an accepted request, and `invalid` is 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Compare request present |
| req_ready | output | 1 | Unit can accept a request |
| req_signaling | input | 1 | 1 selects the signaling variant |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| stat_load | input | 1 | Load the whole status register |
| stat_din | input | 32 | Status load value |
| status | output | 32 | Status register with the condition-code field |
| done | output | 1 | One-cycle pulse: result just written |
| invalid | output | 1 | Invalid-operation flag of the last result |

## Verification
The hardest situation to reach from the ports is a status load that arrives in the same cycle as a compare. The two writers then meet in the same register, and a wrong priority either drops the code or wipes the loaded bits. The bench drives both in one cycle with a load pattern whose field bits differ from the compare's code, so that it sees both halves of the merged word. The borrow path for subnormals is reached through operand pairs that differ only in the lowest mantissa bits. One further pair sits across the boundary from the largest subnormal to the smallest normal.

// File: rtl/fpcmp_pkg.sv
// Package: shared encodings for the floating-point compare unit.
// Assumes: a 2-bit condition code and a 2-bit operand class rank.
package fpcmp_pkg;

    // Condition-code values written into the status field.
    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UO = 2'd3
    } cc_e;

    // Operand class ranked by magnitude; NaN is last and never ranked.
    typedef enum logic [1:0] {
        RK_ZERO = 2'd0,
        RK_FIN  = 2'd1,
        RK_INF  = 2'd2,
        RK_NAN  = 2'd3
    } rank_e;

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Splits one binary floating-point word into its sign, a class rank,
// a signaling-NaN marker and an unsigned magnitude (exponent and mantissa
// taken together, which orders subnormals and normals alike).
// Assumes: the mantissa MSB marks a quiet NaN.
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int MAG_W  = EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output rank_e             rank,
    output logic              snan,
    output logic [MAG_W-1:0]  mag
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             exp_min;
    logic             man_nz;

    assign sign  = word[WORD_W-1];
    assign exp_f = word[WORD_W-2 -: EXP_W];
    assign man_f = word[MAN_W-1:0];
    assign mag   = word[MAG_W-1:0];

    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;
    assign man_nz  = |man_f;

    // Class decode from the exponent and mantissa fields.
    always_comb begin
        if (exp_max && man_nz)      rank = RK_NAN;
        else if (exp_max)           rank = RK_INF;
        else if (exp_min && !man_nz) rank = RK_ZERO;
        else                        rank = RK_FIN;
    end

    assign snan = exp_max && man_nz && !man_f[MAN_W-1];

endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Combinational ordering of two classified operands, giving the condition
// code and the invalid-operation flag.
// Assumes: the ranks and magnitudes come from fpcmp_classify.
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  rank_e            rank_a,
    input  logic             snan_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             sign_b,
    input  rank_e            rank_b,
    input  logic             snan_b,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             signaling,
    output cc_e              cc,
    output logic             invalid
);
    logic [MAG_W:0] diff;
    logic           borrow;
    logic           diff_nz;
    logic           any_nan;
    logic           both_zero;
    cc_e            mag_cc;
    cc_e            same_cc;

    assign diff      = {1'b0, mag_a} - {1'b0, mag_b};
    assign borrow    = diff[MAG_W];
    assign diff_nz   = |diff[MAG_W-1:0];
    assign any_nan   = (rank_a == RK_NAN) || (rank_b == RK_NAN);
    assign both_zero = (rank_a == RK_ZERO) && (rank_b == RK_ZERO);

    // Magnitude ordering: class rank first, then the subtraction.
    always_comb begin
        if (rank_a < rank_b)       mag_cc = CC_LT;
        else if (rank_a > rank_b)  mag_cc = CC_GT;
        else if (rank_a == RK_INF) mag_cc = CC_EQ;
        else if (borrow)           mag_cc = CC_LT;
        else if (diff_nz)          mag_cc = CC_GT;
        else                       mag_cc = CC_EQ;
    end

    // Reverse the magnitude result when both operands are negative.
    always_comb begin
        if (sign_a && mag_cc == CC_LT)      same_cc = CC_GT;
        else if (sign_a && mag_cc == CC_GT) same_cc = CC_LT;
        else                                same_cc = mag_cc;
    end

    // Final priority: NaN, both zero, sign mismatch, magnitude.
    always_comb begin
        if (any_nan)               cc = CC_UO;
        else if (both_zero)        cc = CC_EQ;
        else if (sign_a != sign_b) cc = sign_a ? CC_LT : CC_GT;
        else                       cc = same_cc;
    end

    // Invalid on a signaling NaN always, on any NaN when signaling.
    assign invalid = snan_a || snan_b || (signaling && any_nan);

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Compares two floating-point operands per accepted request and merges the
// 2-bit code into a status register field. It registers the status, the
// invalid flag and a done pulse.
// Assumes: a request is accepted on any cycle with req_valid high (ready is
// always high out of reset). A simultaneous status load supplies the bits
// outside the field.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23,
    parameter int STAT_W = 32,
    parameter int CC_LSB = 10,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int MAG_W  = EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_signaling,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              stat_load,
    input  logic [STAT_W-1:0] stat_din,
    output logic [STAT_W-1:0] status,
    output logic              done,
    output logic              invalid
);
    localparam logic [STAT_W-1:0] CC_MASK = {{(STAT_W-2){1'b0}}, 2'b11} << CC_LSB;

    logic [WORD_W-1:0] ops   [2];
    logic              sign_v[2];
    rank_e             rank_v[2];
    logic              snan_v[2];
    logic [MAG_W-1:0]  mag_v [2];

    cc_e               cc_c;
    logic              inv_c;
    logic              accept;
    logic [STAT_W-1:0] base_c;
    logic [STAT_W-1:0] cc_shift;
    logic [STAT_W-1:0] status_d;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One classifier per operand.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpcmp_classify #(
            .EXP_W(EXP_W),
            .MAN_W(MAN_W)
        ) u_cls (
            .word(ops[g]),
            .sign(sign_v[g]),
            .rank(rank_v[g]),
            .snan(snan_v[g]),
            .mag (mag_v[g])
        );
    end

    fpcmp_order #(
        .MAG_W(MAG_W)
    ) u_ord (
        .sign_a   (sign_v[0]),
        .rank_a   (rank_v[0]),
        .snan_a   (snan_v[0]),
        .mag_a    (mag_v[0]),
        .sign_b   (sign_v[1]),
        .rank_b   (rank_v[1]),
        .snan_b   (snan_v[1]),
        .mag_b    (mag_v[1]),
        .signaling(req_signaling),
        .cc       (cc_c),
        .invalid  (inv_c)
    );

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign cc_shift  = {{(STAT_W-2){1'b0}}, cc_c} << CC_LSB;

    // Next status: the load sets the base and a compare replaces the field.
    always_comb begin
        base_c = stat_load ? stat_din : status;
        if (accept) status_d = (base_c & ~CC_MASK) | cc_shift;
        else        status_d = base_c;
    end

    // Status register, done pulse and invalid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= '0;
            done    <= 1'b0;
            invalid <= 1'b0;
        end else begin
            status  <= status_d;
            done    <= accept;
            invalid <= accept && inv_c;
        end
    end

endmodule

// File: rtl/fpcmp_unit_chk.sv
// Module: fpcmp_unit_chk
// Checker bound to fpcmp_unit. It relates the registered results to the
// request inputs of the cycle before.
module fpcmp_unit_chk #(
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23,
    parameter int STAT_W = 32,
    parameter int CC_LSB = 10,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_signaling,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              stat_load,
    input logic [STAT_W-1:0] stat_din,
    input logic [STAT_W-1:0] status,
    input logic              done,
    input logic              invalid
);
    localparam logic [STAT_W-1:0] CC_MASK = {{(STAT_W-2){1'b0}}, 2'b11} << CC_LSB;

    logic a_nan, b_nan, a_zero, b_zero, any_nan;
    logic [1:0] cc_f;

    assign a_nan   = (&op_a[WORD_W-2 -: EXP_W]) && (|op_a[MAN_W-1:0]);
    assign b_nan   = (&op_b[WORD_W-2 -: EXP_W]) && (|op_b[MAN_W-1:0]);
    assign a_zero  = ~|op_a[WORD_W-2:0];
    assign b_zero  = ~|op_b[WORD_W-2:0];
    assign any_nan = a_nan || b_nan;
    assign cc_f    = status[CC_LSB +: 2];

    // R11: done follows an accepted request by one cycle.
    a_r11_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done == $past(req_valid && req_ready));

    // R11: no invalid flag without a result.
    a_r11_invalid_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !invalid);

    // R1: a NaN operand gives the unordered code.
    a_r1_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_nan) |=> (cc_f == 2'd3));

    // R2: the signaling variant flags any NaN.
    a_r2_signaling_nan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_signaling && any_nan) |=> invalid);

    // R3: no NaN means no invalid flag.
    a_r3_no_nan_no_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_nan) |=> !invalid);

    // R4: two zeros compare equal.
    a_r4_zeros_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_zero && b_zero) |=> (cc_f == 2'd0));

    // R9: with no load, bits outside the field hold.
    a_r9_other_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_load |=> ((status & ~CC_MASK) == $past(status & ~CC_MASK)));

    // R10: a load sets every bit outside the field.
    a_r10_load_outside_field: assert property (@(posedge clk) disable iff (!rst_n)
        stat_load |=> ((status & ~CC_MASK) == $past(stat_din & ~CC_MASK)));

endmodule

bind fpcmp_unit fpcmp_unit_chk #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .STAT_W(STAT_W),
    .CC_LSB(CC_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_signaling(req_signaling),
    .op_a         (op_a),
    .op_b         (op_b),
    .stat_load    (stat_load),
    .stat_din     (stat_din),
    .status       (status),
    .done         (done),
    .invalid      (invalid)
);

// File: tb/fpcmp_unit_test.sv
// Directed bench for fpcmp_unit: one task per scenario, each checking itself.
module fpcmp_unit_test;
    localparam int CC_LSB = 10;
    localparam logic [31:0] MASK = 32'h3 << CC_LSB;

    localparam logic [31:0] PZERO = 32'h0000_0000, NZERO = 32'h8000_0000;
    localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
    localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000, SNAN = 32'h7FA0_0000;
    localparam logic [31:0] DEN1 = 32'h0000_0001, DEN2 = 32'h0000_0002;
    localparam logic [31:0] DMAX = 32'h007F_FFFF, NMIN = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_signaling = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        stat_load = 1'b0;
    logic [31:0] stat_din = '0;
    logic [31:0] status;
    logic        done, invalid;

    int errors = 0;
    int checks = 0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;

    fpcmp_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_signaling(req_signaling), .op_a(op_a), .op_b(op_b),
        .stat_load(stat_load), .stat_din(stat_din), .status(status),
        .done(done), .invalid(invalid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One compare, optionally with a status load in the same cycle.
    task automatic cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic sig, input logic [1:0] ecc, input logic env,
                       input logic ld = 1'b0, input logic [31:0] din = '0);
        @(negedge clk);
        req_valid = 1'b1; op_a = a; op_b = b; req_signaling = sig;
        stat_load = ld; stat_din = din;
        @(negedge clk);
        req_valid = 1'b0; stat_load = 1'b0;
        if (ld) model = din;
        model = (model & ~MASK) | ({30'd0, ecc} << CC_LSB);
        chk(req, "status", status, model);
        chk(req, "invalid", {31'd0, invalid}, {31'd0, env});
        chk(req, "done", {31'd0, done}, 32'd1);
    endtask

    task automatic load_only(input logic [31:0] din);
        @(negedge clk);
        stat_load = 1'b1; stat_din = din;
        @(negedge clk);
        stat_load = 1'b0;
        model = din;
        chk("R10", "load status", status, model);
        chk("R10", "load no done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11", "reset status", status, 32'd0);
        chk("R11", "reset done", {31'd0, done}, 32'd0);
        chk("R11", "reset invalid", {31'd0, invalid}, 32'd0);
        chk("R11", "ready", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_nan();
        cmp("R1", QNAN, P1, 1'b0, 2'd3, 1'b0);
        cmp("R1", NINF, QNAN, 1'b0, 2'd3, 1'b0);
        cmp("R2", P1, QNAN, 1'b1, 2'd3, 1'b1);
        cmp("R2", QNAN, QNAN, 1'b1, 2'd3, 1'b1);
        cmp("R3", SNAN, P1, 1'b0, 2'd3, 1'b1);
        cmp("R3", PZERO, SNAN, 1'b0, 2'd3, 1'b1);
        cmp("R3", P1, P2, 1'b1, 2'd1, 1'b0);
    endtask

    task automatic t_zero_sign();
        cmp("R4", PZERO, NZERO, 1'b0, 2'd0, 1'b0);
        cmp("R4", NZERO, PZERO, 1'b1, 2'd0, 1'b0);
        cmp("R5", N1, P2, 1'b0, 2'd1, 1'b0);
        cmp("R5", P1, N2, 1'b0, 2'd2, 1'b0);
        cmp("R5", NZERO, P1, 1'b0, 2'd1, 1'b0);
        cmp("R5", PZERO, 32'h8000_0001, 1'b0, 2'd2, 1'b0);
        cmp("R5", PINF, NINF, 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_rank();
        cmp("R6", P1, PINF, 1'b0, 2'd1, 1'b0);
        cmp("R6", N1, NINF, 1'b0, 2'd2, 1'b0);
        cmp("R6", PZERO, P1, 1'b0, 2'd1, 1'b0);
        cmp("R6", NZERO, N1, 1'b0, 2'd2, 1'b0);
        cmp("R6", NINF, N2, 1'b0, 2'd1, 1'b0);
        cmp("R7", PINF, PINF, 1'b0, 2'd0, 1'b0);
        cmp("R7", NINF, NINF, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_magnitude();
        cmp("R8", P1, P2, 1'b0, 2'd1, 1'b0);
        cmp("R8", P2, P1, 1'b0, 2'd2, 1'b0);
        cmp("R8", N1, N2, 1'b0, 2'd2, 1'b0);
        cmp("R8", P2, P2, 1'b0, 2'd0, 1'b0);
        cmp("R8", DEN1, DEN2, 1'b0, 2'd1, 1'b0);
        cmp("R8", DMAX, NMIN, 1'b0, 2'd1, 1'b0);
        cmp("R8", DEN2 | NZERO, DEN1 | NZERO, 1'b0, 2'd1, 1'b0);
        cmp("R8", 32'h3F80_0001, P1, 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_field();
        load_only(32'hFFFF_FFFF);
        cmp("R9", P1, P1, 1'b0, 2'd0, 1'b0);
        cmp("R9", P1, P2, 1'b0, 2'd1, 1'b0);
        cmp("R9", P2, P1, 1'b0, 2'd2, 1'b0);
        cmp("R10", P2, P1, 1'b0, 2'd2, 1'b0, 1'b1, 32'h1234_5678);
        cmp("R10", P1, P1, 1'b0, 2'd0, 1'b0, 1'b1, 32'hA5A5_AFA5);
        @(negedge clk);
        chk("R11", "done one cycle", {31'd0, done}, 32'd0);
        chk("R11", "invalid idle", {31'd0, invalid}, 32'd0);
        chk("R9", "status held", status, model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nan();
        t_zero_sign();
        t_rank();
        t_magnitude();
        t_field();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule